// File: doc/BRIEF.md
# Byte-Lane Register Access Front-End

This block connects a plain synchronous host bus to a bank of 16-bit configuration and status registers. The registers are repeated across several identical channel slices. The host bus runs either 8 bits or 16 bits wide, set by a static mode input. The upper address bits pick a slice window. The lower bits pick a register within that window. Address bit 0 has a different job in each bus mode: in byte mode it selects which half of a register is accessed, and in word mode it exchanges the two bytes of the data word.

Every register has a host-visible shadow copy. It also has an applied copy, which drives the channel logic. The applied copy follows the shadow one clock later. While the data-path reset input is high, the applied copy is frozen, but the host can still write and read the shadow. When that reset is released, the channel logic sees the final shadow value. Action bits are edge-detected only on that applied value.

Writes are silently dropped in four cases: to slices that are not fitted, to offsets that are not mapped, to read-only fields, and to reserved bits. Reads from slices that are not fitted and from unmapped offsets return zero.

Top module: `regfe_top`

## Requirements
- R1: When `busMode16`=0, address bit 0 = 0 selects register bits [7:0] and address bit 0 = 1 selects bits [15:8]. Write data is taken from `wrData[7:0]`, and only the selected byte is changed. The read byte appears on `rdData[7:0]`, and `rdData[15:8]` reads 0.
- R2: When `busMode16`=1 and address bit 0 = 1, the bytes are exchanged on both writes and reads. The register receives `{wrData[7:0],wrData[15:8]}`, and `rdData` returns `{reg[7:0],reg[15:8]}`. With address bit 0 = 0, the word passes straight through.
- R3: The slice is `addr[10:8]` and the register index is `addr[2:1]`. Index 0 is CTRL, 1 is ACTN, 2 is STAT and 3 is MIX. For slice numbers at or above `POP_SLICES` (default 6), writes are ignored and reads return 0.
- R4: In a fitted slice, any offset with `addr[7:3]` not zero is unmapped. Reads of an unmapped offset return 0, and writes to it change no register.
- R5: Only these bits can be written: CTRL 16'hF0FF, ACTN 16'h00FF, MIX 16'h00FF. Reserved bits (CTRL[11:8], ACTN[15:8], MIX[11:8]) always read 0, and their applied copies are always 0.
- R6: STAT is read-only and reads `statIn[slice]`. MIX[15:12] is read-only and reads `statIn[slice][3:0]`. Writes do not alter either field.
- R7: After `rstN` is low, both the shadow and applied copies take the defaults CTRL 16'h1005, ACTN 16'h0040, MIX 16'h00A5.
- R8: A write changes the shadow on the rising edge where `wrEn` is sampled. `rdData` is loaded on the edge where `rdEn` is sampled and holds while `rdEn` is low.
- R9: The applied outputs `ctrlOut`, `actnOut` and `mixOut` copy the shadow on every edge where `dpReset` is low. They hold while `dpReset` is high. The shadow stays writable and readable during that time.
- R10: `startPulse[s]` is high for exactly one cycle when applied ACTN bit 0 of slice s goes from 0 to 1. Toggles of the shadow while `dpReset` is high count only through the value present at release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset to defaults |
| busMode16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus (static) |
| addr | input | ADDR_W (11) | Byte address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Registered read data |
| dpReset | input | 1 | Data-path reset; freezes the applied copies |
| statIn | input | POP_SLICES x 16 | Status inputs per slice |
| ctrlOut | output | POP_SLICES x 16 | Applied CTRL per slice |
| actnOut | output | POP_SLICES x 16 | Applied ACTN per slice |
| mixOut | output | POP_SLICES x 16 | Applied MIX writable bits per slice |
| startPulse | output | POP_SLICES | One-cycle action pulse per slice |

## Verification
Read data for a strobe sampled at edge T is on `rdData` just after T. The bench drives on falling edges and compares at the falling edge that follows. A write at edge T reaches the applied outputs at edge T+1. The bench therefore checks the old value at the first falling edge after the write and the new value at the second. A start pulse is due between edges T+1 and T+2, and it is checked at three consecutive falling edges, including across a data-path reset release.

// File: rtl/regfe_pkg.sv
package regfe_pkg;
  localparam int REG_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int REG_CNT = 4;
  localparam int IDX_W   = 2;

  typedef enum logic [IDX_W-1:0] {
    REG_CTRL = 2'd0,
    REG_ACTN = 2'd1,
    REG_STAT = 2'd2,
    REG_MIX  = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic     hit;
    reg_idx_e regIdx;
    logic     wrLo;
    logic     wrHi;
    logic     rdGo;
    logic     laneHi;
    logic     swap;
    logic     wide;
  } strobe_t;

  function automatic logic [REG_W-1:0] wrMaskOf(reg_idx_e idx);
    case (idx)
      REG_CTRL: return 16'hF0FF;
      REG_ACTN: return 16'h00FF;
      REG_MIX:  return 16'h00FF;
      default:  return 16'h0000;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] defaultOf(reg_idx_e idx);
    case (idx)
      REG_CTRL: return 16'h1005;
      REG_ACTN: return 16'h0040;
      REG_MIX:  return 16'h00A5;
      default:  return 16'h0000;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] roViewOf(reg_idx_e idx, logic [REG_W-1:0] stat);
    case (idx)
      REG_STAT: return stat;
      REG_MIX:  return {stat[3:0], 12'h000};
      default:  return 16'h0000;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] swapBytes(logic [REG_W-1:0] w);
    return {w[BYTE_W-1:0], w[REG_W-1:BYTE_W]};
  endfunction
endpackage

// File: rtl/regfe_ctrl.sv
module regfe_ctrl
  import regfe_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int SLICE_W    = 3,
  parameter int POP_SLICES = 6
) (
  input  logic                  busMode16,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wrEn,
  input  logic                  rdEn,
  output strobe_t               stb,
  output logic [POP_SLICES-1:0] sliceSel
);
  localparam int OFF_W = ADDR_W - SLICE_W;

  logic [SLICE_W-1:0] winIdx;
  logic [OFF_W-1:0]   offset;
  logic               populated;
  logic               mapped;
  logic               hit;
  logic               byteHi;

  assign winIdx    = addr[ADDR_W-1 -: SLICE_W];
  assign offset    = addr[OFF_W-1:0];
  assign populated = int'(winIdx) < POP_SLICES;
  assign mapped    = (offset[OFF_W-1:IDX_W+1] == '0);
  assign hit       = populated && mapped;
  assign byteHi    = addr[0];

  for (genvar s = 0; s < POP_SLICES; s++) begin : g_sel
    assign sliceSel[s] = hit && (int'(winIdx) == s);
  end

  always_comb begin
    stb.hit    = hit;
    stb.regIdx = reg_idx_e'(offset[IDX_W:1]);
    stb.wrLo   = wrEn && hit && (busMode16 || !byteHi);
    stb.wrHi   = wrEn && hit && (busMode16 || byteHi);
    stb.rdGo   = rdEn;
    stb.laneHi = byteHi;
    stb.swap   = busMode16 && byteHi;
    stb.wide   = busMode16;
  end
endmodule

// File: rtl/regfe_dpath.sv
module regfe_dpath
  import regfe_pkg::*;
#(
  parameter int POP_SLICES = 6
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 dpReset,
  input  strobe_t                              stb,
  input  logic [POP_SLICES-1:0]                sliceSel,
  input  logic [REG_W-1:0]                     wrData,
  input  logic [POP_SLICES-1:0][REG_W-1:0]     statIn,
  output logic [REG_W-1:0]                     rdData,
  output logic [POP_SLICES-1:0][REG_W-1:0]     ctrlOut,
  output logic [POP_SLICES-1:0][REG_W-1:0]     actnOut,
  output logic [POP_SLICES-1:0][REG_W-1:0]     mixOut,
  output logic [POP_SLICES-1:0]                startPulse
);
  logic [REG_W-1:0] wrWord;
  logic [REG_W-1:0] byteEn;
  logic [REG_W-1:0] rdWord;
  logic [REG_W-1:0] rdNext;
  logic [POP_SLICES-1:0][REG_CNT-1:0][REG_W-1:0] shadowVec;

  // Byte steering of the incoming word
  assign wrWord = stb.wide ? (stb.swap ? swapBytes(wrData) : wrData)
                           : {wrData[BYTE_W-1:0], wrData[BYTE_W-1:0]};
  assign byteEn = {{BYTE_W{stb.wrHi}}, {BYTE_W{stb.wrLo}}};

  for (genvar s = 0; s < POP_SLICES; s++) begin : g_slice
    for (genvar r = 0; r < REG_CNT; r++) begin : g_reg
      localparam reg_idx_e         RI = reg_idx_e'(r);
      localparam logic [REG_W-1:0] WM = wrMaskOf(RI);
      localparam logic [REG_W-1:0] DV = defaultOf(RI);
      if (WM != '0) begin : g_rw
        logic [REG_W-1:0] shadowQ;
        logic [REG_W-1:0] appliedQ;
        logic             wrSel;
        assign wrSel = sliceSel[s] && (stb.regIdx == RI);

        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            shadowQ <= DV;
          end else if (wrSel) begin
            shadowQ <= (shadowQ & ~(byteEn & WM)) | (wrWord & byteEn & WM);
          end
        end

        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            appliedQ <= DV;
          end else if (!dpReset) begin
            appliedQ <= shadowQ;
          end
        end

        assign shadowVec[s][r] = shadowQ;
        if (RI == REG_CTRL) begin : g_ctrl
          assign ctrlOut[s] = appliedQ;
        end else if (RI == REG_ACTN) begin : g_actn
          assign actnOut[s] = appliedQ;
        end else begin : g_mix
          assign mixOut[s] = appliedQ;
        end
      end else begin : g_ro
        assign shadowVec[s][r] = '0;
      end
    end

    // Edge detect on the applied action bit
    logic actnPrev;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) actnPrev <= 1'b0;
      else       actnPrev <= actnOut[s][0];
    end
    assign startPulse[s] = actnOut[s][0] && !actnPrev;
  end

  // Read selection across slices
  always_comb begin
    rdWord = '0;
    for (int s = 0; s < POP_SLICES; s++) begin
      if (stb.hit && sliceSel[s]) begin
        rdWord = rdWord | shadowVec[s][stb.regIdx] | roViewOf(stb.regIdx, statIn[s]);
      end
    end
  end

  assign rdNext = stb.wide ? (stb.swap ? swapBytes(rdWord) : rdWord)
                           : {{BYTE_W{1'b0}},
                              (stb.laneHi ? rdWord[REG_W-1:BYTE_W] : rdWord[BYTE_W-1:0])};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (stb.rdGo) rdData <= rdNext;
  end
endmodule

// File: rtl/regfe_top.sv
module regfe_top
  import regfe_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int SLICE_W    = 3,
  parameter int POP_SLICES = 6
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busMode16,
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             wrEn,
  input  logic                             rdEn,
  input  logic [15:0]                      wrData,
  output logic [15:0]                      rdData,
  input  logic                             dpReset,
  input  logic [POP_SLICES-1:0][15:0]      statIn,
  output logic [POP_SLICES-1:0][15:0]      ctrlOut,
  output logic [POP_SLICES-1:0][15:0]      actnOut,
  output logic [POP_SLICES-1:0][15:0]      mixOut,
  output logic [POP_SLICES-1:0]            startPulse
);
  strobe_t               stb;
  logic [POP_SLICES-1:0] sliceSel;

  regfe_ctrl #(
    .ADDR_W(ADDR_W), .SLICE_W(SLICE_W), .POP_SLICES(POP_SLICES)
  ) u_ctrl (
    .busMode16(busMode16), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .stb(stb), .sliceSel(sliceSel)
  );

  regfe_dpath #(
    .POP_SLICES(POP_SLICES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .dpReset(dpReset), .stb(stb), .sliceSel(sliceSel),
    .wrData(wrData), .statIn(statIn), .rdData(rdData), .ctrlOut(ctrlOut),
    .actnOut(actnOut), .mixOut(mixOut), .startPulse(startPulse)
  );
endmodule

// File: rtl/regfe_chk.sv
module regfe_chk #(
  parameter int ADDR_W     = 11,
  parameter int SLICE_W    = 3,
  parameter int POP_SLICES = 6
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        busMode16,
  input logic [ADDR_W-1:0]           addr,
  input logic                        rdEn,
  input logic [15:0]                 rdData,
  input logic                        dpReset,
  input logic [POP_SLICES-1:0][15:0] ctrlOut,
  input logic [POP_SLICES-1:0][15:0] actnOut,
  input logic [POP_SLICES-1:0][15:0] mixOut,
  input logic [POP_SLICES-1:0]       startPulse
);
  logic resvSeen;
  logic unpopAddr;

  always_comb begin
    resvSeen = 1'b0;
    for (int s = 0; s < POP_SLICES; s++) begin
      resvSeen = resvSeen || (ctrlOut[s][11:8] != 4'h0) || (actnOut[s][15:8] != 8'h00)
                          || (mixOut[s][15:8] != 8'h00);
    end
  end
  assign unpopAddr = int'(addr[ADDR_W-1 -: SLICE_W]) >= POP_SLICES;

  assert_byte_lane_hi_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !busMode16) |=> (rdData[15:8] == 8'h00));

  assert_unpop_read_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && unpopAddr) |=> (rdData == 16'h0000));

  assert_reserved_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    !resvSeen);

  assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rstN)
    dpReset |=> ($stable(ctrlOut) && $stable(actnOut) && $stable(mixOut)));

  assert_pulse_after_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|startPulse) |-> !$past(dpReset));

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(|(startPulse & $past(startPulse))));
endmodule

bind regfe_top regfe_chk #(
  .ADDR_W(ADDR_W), .SLICE_W(SLICE_W), .POP_SLICES(POP_SLICES)
) u_chk (
  .clk(clk), .rstN(rstN), .busMode16(busMode16), .addr(addr), .rdEn(rdEn),
  .rdData(rdData), .dpReset(dpReset), .ctrlOut(ctrlOut), .actnOut(actnOut),
  .mixOut(mixOut), .startPulse(startPulse)
);

// File: tb/sim_regfe_top.sv
module sim_regfe_top;
  localparam int CLK_PERIOD = 10;
  localparam int POP = 6;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 busMode16 = 1'b1;
  logic [10:0]          addr = '0;
  logic                 wrEn = 1'b0;
  logic                 rdEn = 1'b0;
  logic [15:0]          wrData = '0;
  logic [15:0]          rdData;
  logic                 dpReset = 1'b0;
  logic [POP-1:0][15:0] statIn = '0;
  logic [POP-1:0][15:0] ctrlOut, actnOut, mixOut;
  logic [POP-1:0]       startPulse;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;
  logic [15:0] mShadow [POP][4];

  regfe_top #(.ADDR_W(11), .SLICE_W(3), .POP_SLICES(POP)) u0 (
    .clk(clk), .rstN(rstN), .busMode16(busMode16), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .dpReset(dpReset),
    .statIn(statIn), .ctrlOut(ctrlOut), .actnOut(actnOut), .mixOut(mixOut),
    .startPulse(startPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] bMask(int idx);
    case (idx)
      0: return 16'hF0FF;
      1: return 16'h00FF;
      3: return 16'h00FF;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] bDefault(int idx);
    case (idx)
      0: return 16'h1005;
      1: return 16'h0040;
      3: return 16'h00A5;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [10:0] mkAddr(int slice, int off);
    return {slice[2:0], off[7:0]};
  endfunction

  task automatic modelReset();
    for (int s = 0; s < POP; s++)
      for (int r = 0; r < 4; r++) mShadow[s][r] = bDefault(r);
  endtask

  task automatic modelWrite(bit m16, logic [10:0] a, logic [15:0] d);
    int s, idx;
    logic [15:0] word, be, msk;
    s = int'(a[10:8]);
    idx = int'(a[2:1]);
    if (s >= POP || a[7:3] != 0) return;
    msk = bMask(idx);
    if (m16) begin
      word = a[0] ? {d[7:0], d[15:8]} : d;
      be = 16'hFFFF;
    end else begin
      word = {d[7:0], d[7:0]};
      be = a[0] ? 16'hFF00 : 16'h00FF;
    end
    mShadow[s][idx] = (mShadow[s][idx] & ~(be & msk)) | (word & be & msk);
  endtask

  function automatic logic [15:0] modelRead(bit m16, logic [10:0] a);
    int s, idx;
    logic [15:0] w;
    s = int'(a[10:8]);
    idx = int'(a[2:1]);
    if (s >= POP || a[7:3] != 0) w = 16'h0000;
    else if (idx == 2) w = statIn[s];
    else if (idx == 3) w = mShadow[s][3] | {statIn[s][3:0], 12'h000};
    else w = mShadow[s][idx];
    if (m16) return a[0] ? {w[7:0], w[15:8]} : w;
    return {8'h00, (a[0] ? w[15:8] : w[7:0])};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Tasks start and end just after a falling edge
  task automatic doWrite(logic [10:0] a, logic [15:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    modelWrite(busMode16, a, d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(logic [10:0] a, string tag);
    logic [15:0] exp;
    addr = a; rdEn = 1'b1;
    exp = modelRead(busMode16, a);
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b0;
    check(tag, rdData, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED);
    for (int s = 0; s < POP; s++) statIn[s] = 16'hC3A0 + 16'(s);
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R7 reset defaults, shadow and applied
    doRead(mkAddr(0, 0), "R7 ctrl default");
    doRead(mkAddr(0, 2), "R7 actn default");
    doRead(mkAddr(5, 6), "R7 mix default");
    check("R7 ctrlOut default", ctrlOut[2], 16'h1005);
    check("R7 actnOut default", actnOut[2], 16'h0040);
    check("R7 mixOut default", mixOut[2], 16'h00A5);

    // R5 write masks and reserved bits
    doWrite(mkAddr(1, 0), 16'hFFFF);
    doRead(mkAddr(1, 0), "R5 ctrl mask");
    check("R5 ctrl mask literal", rdData, 16'hF0FF);

    // R2 word swap on write and read
    doWrite(mkAddr(1, 1), 16'h1234);
    doRead(mkAddr(1, 0), "R2 swapped write");
    check("R2 swapped write literal", rdData, 16'h3012);
    doRead(mkAddr(1, 1), "R2 swapped read");
    check("R2 swapped read literal", rdData, 16'h1230);

    // R1 byte lanes
    busMode16 = 1'b0;
    doWrite(mkAddr(2, 1), 16'h55AB);
    doRead(mkAddr(2, 0), "R1 low lane");
    check("R1 low lane literal", rdData, 16'h0005);
    doRead(mkAddr(2, 1), "R1 high lane");
    check("R1 high lane literal", rdData, 16'h00A0);
    doWrite(mkAddr(2, 0), 16'hEE77);
    doRead(mkAddr(2, 1), "R1 high lane kept");

    // R3 unpopulated slices
    doWrite(mkAddr(7, 0), 16'h00FF);
    doRead(mkAddr(7, 0), "R3 unpop byte read");
    busMode16 = 1'b1;
    doWrite(mkAddr(6, 2), 16'hFFFF);
    doRead(mkAddr(6, 2), "R3 unpop word read");
    check("R3 unpop literal", rdData, 16'h0000);

    // R4 unmapped offsets do not alias
    doWrite(mkAddr(0, 8'h10), 16'h0F0F);
    doRead(mkAddr(0, 8'h10), "R4 unmapped read");
    doRead(mkAddr(0, 0), "R4 no alias");
    check("R4 no alias literal", rdData, 16'h1005);

    // R6 read-only fields
    doWrite(mkAddr(0, 4), 16'hFFFF);
    doRead(mkAddr(0, 4), "R6 stat read");
    check("R6 stat literal", rdData, 16'hC3A0);
    doWrite(mkAddr(3, 6), 16'hFFFF);
    doRead(mkAddr(3, 6), "R6 mix ro bits");
    check("R6 mix literal", rdData, 16'h30FF);

    // R9 applied copy lags shadow by one edge
    doWrite(mkAddr(3, 0), 16'h2077);
    check("R9 applied still old", ctrlOut[3], 16'h1005);
    @(negedge clk);
    check("R9 applied new", ctrlOut[3], 16'h2077);

    // R8 read hold when strobe low
    doRead(mkAddr(3, 0), "R8 read");
    addr = mkAddr(0, 4);
    repeat (2) @(negedge clk);
    check("R8 rdData held", rdData, 16'h2077);

    // R10 start pulse timing
    doWrite(mkAddr(4, 2), 16'h0041);
    check("R10 no pulse yet", 16'(startPulse[4]), 16'h0);
    @(negedge clk);
    check("R10 pulse", 16'(startPulse[4]), 16'h1);
    @(negedge clk);
    check("R10 pulse ends", 16'(startPulse[4]), 16'h0);
    doWrite(mkAddr(4, 2), 16'h0040);
    repeat (2) @(negedge clk);

    // R9/R10 freeze during data-path reset
    dpReset = 1'b1;
    @(negedge clk);
    doWrite(mkAddr(4, 2), 16'h0041);
    doWrite(mkAddr(4, 2), 16'h0040);
    doWrite(mkAddr(4, 2), 16'h00C1);
    check("R9 frozen actn", actnOut[4], 16'h0040);
    check("R10 no pulse in reset", 16'(startPulse[4]), 16'h0);
    doRead(mkAddr(4, 2), "R9 shadow readable");
    dpReset = 1'b0;
    @(negedge clk);
    check("R10 pulse at release", 16'(startPulse[4]), 16'h1);
    check("R9 applied at release", actnOut[4], 16'h00C1);
    @(negedge clk);
    check("R10 pulse one cycle", 16'(startPulse[4]), 16'h0);

    dpReset = 1'b1;
    @(negedge clk);
    doWrite(mkAddr(4, 2), 16'h0040);
    doWrite(mkAddr(4, 2), 16'h0041);
    dpReset = 1'b0;
    @(negedge clk);
    check("R10 no pulse when final stays 1", 16'(startPulse[4]), 16'h0);
    @(negedge clk);
    check("R10 still no pulse", 16'(startPulse[4]), 16'h0);

    // Random phase, all requirements through the model
    for (int i = 0; i < 600; i++) begin
      int pick, sl, off;
      pick = $urandom_range(9, 0);
      sl = $urandom_range(7, 0);
      off = ($urandom_range(7, 0) == 0) ? $urandom_range(255, 0) : $urandom_range(7, 0);
      if (pick == 0) begin
        busMode16 = $urandom_range(1, 0);
        @(negedge clk);
      end else if (pick == 1) begin
        statIn[$urandom_range(POP-1, 0)] = 16'($urandom);
        @(negedge clk);
      end else if (pick < 6) begin
        doWrite(mkAddr(sl, off), 16'($urandom));
      end else begin
        doRead(mkAddr(sl, off), "R1 R2 R3 R4 R5 R6 random read");
      end
    end

    busMode16 = 1'b1;
    @(negedge clk);
    for (int s = 0; s < POP; s++) begin
      check("R9 random ctrl applied", ctrlOut[s], mShadow[s][0]);
      check("R9 random mix applied", mixOut[s], mShadow[s][3]);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule